// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block is the digital front end of an eight-channel switch array. A host clocks serial data into an internal eight-bit register, one bit per rising edge of a shift clock. A parallel latch sits between that register and the eight channel enables. A 1 on an enable closes its switch and a 0 opens it. While latch-enable is low, the latch passes the register through. When latch-enable rises, the latch freezes the register contents and keeps them for as long as latch-enable stays high. An active-high clear opens every channel at once. A serial output carries the bit leaving the register, so several of these blocks can be chained on one data line.

The pins (shift clock, serial data, latch-enable) are sampled by a core clock through a synchronizer. The shift clock, at up to 5 MHz, is edge-detected in the core domain. A two-state machine runs the latch. In state `LAT_PASS` the outputs follow the register. The transition PASS→HOLD fires when the synchronized latch-enable is high, and it loads the hold register in the same cycle. In state `LAT_HOLD` the outputs show the hold register. The transition HOLD→PASS fires when the synchronized latch-enable is low. Clear resets the machine to `LAT_PASS` and zeroes every register.

Top module: `serial_switch_ctl`

## Requirements
- R1: While `clr` is high, all `sw` bits and `sdout` are 0, and the shift register is all zeros.
- R2: Each rising edge of `sclk` shifts `sdin` into the register. After eight shifts, the most recent bit sits in `sw[0]` and the earliest in `sw[7]`.
- R3: While `le` is low, `sw` follows the shift register after every shift.
- R4: On a rising edge of `le`, the register contents at that moment are captured and appear on `sw`.
- R5: While `le` is high, shifting changes the register and `sdout` but leaves `sw` unchanged.
- R6: When `le` falls, `sw` again shows the register, including any bits shifted in while `le` was high.
- R7: `sdout` equals the bit that was shifted in eight `sclk` rising edges earlier, which is register bit 7. After a clear it is 0.
- R8: Clear overrides `le` and `sclk`: asserting it while `le` is high still forces `sw` to 0. After it is released the register holds zeros.
- R9: A pin change is reflected at `sw`/`sdout` within SYNC_STAGES+2 core clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core sampling clock |
| clr | input | 1 | Asynchronous active-high clear, opens all channels |
| sclk | input | 1 | Serial shift clock pin (rising edge shifts) |
| sdin | input | 1 | Serial data input |
| le | input | 1 | Latch-enable: low = transparent, high = hold |
| sw | output | CHANNELS | Channel enables, 1 = switch closed |
| sdout | output | 1 | Serial data output for chaining |

## Verification
The assertions assume the pins are sampled cleanly by the core clock. `sdin` must be stable for several core cycles around each `sclk` rise, and `le` must never change in the same core cycle as an `sclk` edge. Only then do the captured value and the shift order have a single meaning. The stimulus holds every pin level for at least four core cycles and changes `sdin` only while `sclk` is low. It also moves `le` only between complete shift pulses. Results are compared only after every pin has been quiet longer than the synchronizer latency.

// File: rtl/sw_ctl_pkg.sv
package sw_ctl_pkg;

    typedef enum logic [0:0] {
        LAT_PASS = 1'b0,
        LAT_HOLD = 1'b1
    } lat_state_e;

    localparam int PIN_COUNT = 3;
    localparam int PIN_DIN   = 0;
    localparam int PIN_SCLK  = 1;
    localparam int PIN_LE    = 2;

endpackage

// File: rtl/sw_ctl_sync.sv
module sw_ctl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or posedge clr) begin
                    if (clr) stage[i] <= '0;
                    else     stage[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge clr) begin
                    if (clr) stage[i] <= '0;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/sw_ctl_edge.sv
module sw_ctl_edge (
    input  logic clk,
    input  logic clr,
    input  logic lvl,
    output logic rise
);

    logic lvl_q;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/sw_ctl_shift.sv
module sw_ctl_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr)           q <= '0;
        else if (shift_en) q <= {q[WIDTH-2:0], bit_in};
    end

    assign ser_out = q[WIDTH-1];

endmodule

// File: rtl/sw_ctl_latch.sv
module sw_ctl_latch
    import sw_ctl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             le_lvl,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output lat_state_e       state
);

    lat_state_e       nxt;
    logic [WIDTH-1:0] hold_q;

    always_comb begin
        nxt = state;
        unique case (state)
            LAT_PASS: if (le_lvl)  nxt = LAT_HOLD;
            LAT_HOLD: if (!le_lvl) nxt = LAT_PASS;
            default:  nxt = LAT_PASS;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) state <= LAT_PASS;
        else     state <= nxt;
    end

    // capture on the PASS->HOLD transition
    always_ff @(posedge clk or posedge clr) begin
        if (clr)                                hold_q <= '0;
        else if (state == LAT_PASS && le_lvl)   hold_q <= d;
    end

    always_comb begin
        unique case (state)
            LAT_PASS: q = d;
            LAT_HOLD: q = hold_q;
            default:  q = '0;
        endcase
    end

endmodule

// File: rtl/serial_switch_ctl.sv
module serial_switch_ctl
    import sw_ctl_pkg::*;
#(
    parameter int CHANNELS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                sclk,
    input  logic                sdin,
    input  logic                le,
    output logic [CHANNELS-1:0] sw,
    output logic                sdout
);

    logic [PIN_COUNT-1:0] pins_s;
    logic                 din_s;
    logic                 sclk_s;
    logic                 le_s;
    logic                 shift_pulse;
    logic [CHANNELS-1:0]  sreg;
    lat_state_e           lat_st;

    sw_ctl_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .clr (clr),
        .d   ({le, sclk, sdin}),
        .q   (pins_s)
    );

    assign din_s  = pins_s[PIN_DIN];
    assign sclk_s = pins_s[PIN_SCLK];
    assign le_s   = pins_s[PIN_LE];

    sw_ctl_edge u_edge (
        .clk  (clk),
        .clr  (clr),
        .lvl  (sclk_s),
        .rise (shift_pulse)
    );

    sw_ctl_shift #(.WIDTH(CHANNELS)) u_shift (
        .clk      (clk),
        .clr      (clr),
        .shift_en (shift_pulse),
        .bit_in   (din_s),
        .q        (sreg),
        .ser_out  (sdout)
    );

    sw_ctl_latch #(.WIDTH(CHANNELS)) u_latch (
        .clk    (clk),
        .clr    (clr),
        .le_lvl (le_s),
        .d      (sreg),
        .q      (sw),
        .state  (lat_st)
    );

endmodule

// File: rtl/serial_switch_ctl_chk.sv
module serial_switch_ctl_chk
    import sw_ctl_pkg::*;
#(
    parameter int CHANNELS = 8
) (
    input logic                clk,
    input logic                clr,
    input logic [CHANNELS-1:0] sw,
    input logic                sdout,
    input logic [CHANNELS-1:0] sreg,
    input logic                shift_pulse,
    input logic                din_s,
    input logic                le_s,
    input lat_state_e          lat_st
);

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        clr |-> (sw == '0 && sdout == 1'b0));

    // R3
    pass_follow_chk: assert property (@(posedge clk) disable iff (clr)
        (lat_st == LAT_PASS && !le_s && shift_pulse) |=> (sw[0] == $past(din_s)));

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (clr)
        (lat_st == LAT_PASS && le_s) |=> (sw == $past(sreg)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (clr)
        (lat_st == LAT_HOLD && le_s) |=> $stable(sw));

    // R7
    chain_out_chk: assert property (@(posedge clk) disable iff (clr)
        shift_pulse |=> (sdout == $past(sreg[CHANNELS-2])));

endmodule

bind serial_switch_ctl serial_switch_ctl_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk         (clk),
    .clr         (clr),
    .sw          (sw),
    .sdout       (sdout),
    .sreg        (sreg),
    .shift_pulse (shift_pulse),
    .din_s       (din_s),
    .le_s        (le_s),
    .lat_st      (lat_st)
);

// File: tb/test_serial_switch_ctl.sv
module test_serial_switch_ctl;

    localparam int CH = 8;

    typedef struct {
        logic [CH-1:0] sw;
        logic          dout;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic          sclk = 1'b0;
    logic          sdin = 1'b0;
    logic          le = 1'b0;
    logic [CH-1:0] sw;
    logic          sdout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [CH-1:0] m_sreg = '0;
    logic [CH-1:0] m_hold = '0;
    logic          m_le = 1'b0;

    exp_t exp_q[$];
    event sample_ev;

    always #4 clk = ~clk;

    serial_switch_ctl #(.CHANNELS(CH), .SYNC_STAGES(2)) i_serial_switch_ctl (
        .clk   (clk),
        .clr   (clr),
        .sclk  (sclk),
        .sdin  (sdin),
        .le    (le),
        .sw    (sw),
        .sdout (sdout)
    );

    // monitor: pops an expectation and compares it with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (sw !== e.sw || sdout !== e.dout) begin
                    n_fail++;
                    $display("FAIL %s: sw=%h sdout=%b expected sw=%h sdout=%b",
                             e.tag, sw, sdout, e.sw, e.dout);
                end
            end
        end
    end

    task automatic expect_now(input string tag);
        exp_t e;
        repeat (6) @(negedge clk);
        e.sw   = clr ? '0 : (m_le ? m_hold : m_sreg);
        e.dout = clr ? 1'b0 : m_sreg[CH-1];
        e.tag  = tag;
        exp_q.push_back(e);
        -> sample_ev;
        @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        sdin = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        m_sreg = {m_sreg[CH-2:0], b};
    endtask

    task automatic set_le(input logic v);
        @(negedge clk);
        le = v;
        if (v && !m_le) m_hold = m_sreg;
        m_le = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr = 1'b1;
        m_sreg = '0;
        m_hold = '0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        expect_now("R1");
        clr = 1'b0;
        repeat (4) @(negedge clk);
        expect_now("R1");

        // R2/R3: load 8'hA5, earliest bit first, watching every step
        for (int i = CH - 1; i >= 0; i--) begin
            logic [7:0] pat = 8'hA5;
            shift_bit(pat[i]);
            expect_now("R3");
        end
        expect_now("R2");

        // R7: next byte pushes the first one out on sdout
        for (int i = CH - 1; i >= 0; i--) begin
            logic [7:0] pat = 8'h3C;
            shift_bit(pat[i]);
            expect_now("R7");
        end

        // R4: capture
        set_le(1'b1);
        expect_now("R4");

        // R5: shifts while held leave sw unchanged
        for (int i = 0; i < 5; i++) begin
            shift_bit(i[0]);
            expect_now("R5");
        end

        // R6: release shows the register
        set_le(1'b0);
        expect_now("R6");
        shift_bit(1'b1);
        expect_now("R6");

        // R8: clear while holding and shifting
        set_le(1'b1);
        shift_bit(1'b1);
        pulse_clear();
        expect_now("R8");
        @(negedge clk);
        clr = 1'b0;
        repeat (4) @(negedge clk);
        expect_now("R8");
        set_le(1'b0);
        expect_now("R8");

        // R9: one shift seen within SYNC_STAGES+2 core cycles
        @(negedge clk);
        sdin = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        m_sreg = {m_sreg[CH-2:0], 1'b1};
        repeat (4) @(negedge clk);
        n_chk++;
        if (sw !== m_sreg) begin
            n_fail++;
            $display("FAIL R9: sw=%h expected %h", sw, m_sreg);
        end
        sclk = 1'b0;
        repeat (4) @(negedge clk);

        // R1: clear while transparent
        pulse_clear();
        expect_now("R1");
        @(negedge clk);
        clr = 1'b0;

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule